// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache

The block keeps a small, fully associative store of recently used page-to-frame mappings so that most memory references avoid a walk of the page table. Each stored mapping carries the virtual page number, the number of the address space that owns it, the physical frame number and a permit bit. A lookup compares the presented page number and address-space number against every slot in the same cycle. One clock later the block reports one of three outcomes:

- a hit, with the frame number;
- a protection fault, when the matching mapping is marked not permitted;
- a miss, which tells the requester to fetch the mapping from the page table.

Mappings arrive on a separate fill port. A fill goes into an empty slot when one exists. When every slot is occupied, the fill replaces the mapping that was used least recently. A fill whose page and address space are already present rewrites that slot in place. Because each slot is tagged with its address space, mappings from several processes can stay resident across context switches. Software-driven maintenance can drop all mappings of a single address space, or every mapping at once.

Top module: `asid_tlb`

## Requirements
- R1: `rsp_valid` is high in exactly those cycles that follow a cycle with `lk_req` high, and then exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. All four are low otherwise.
- R2: A lookup that matches an occupied slot on both page number and address-space number, where that slot's permit bit is 1, returns `rsp_hit`=1 and that slot's frame number on `rsp_pfn`.
- R3: A lookup that matches no occupied slot returns `rsp_miss`=1 with `rsp_pfn`=0.
- R4: A slot holding the same page number under a different address-space number does not match.
- R5: A lookup that matches a slot whose permit bit is 0 returns `rsp_fault`=1, `rsp_hit`=0 and `rsp_pfn`=0.
- R6: A fill accepted at a clock edge is visible to a lookup presented in the next cycle.
- R7: While any slot is empty, a fill of a new mapping takes an empty slot and evicts nothing. Eight distinct fills after reset all stay resident.
- R8: When all slots are occupied, a fill of a new mapping replaces the least recently used mapping. Both a fill and a lookup that matches a slot (hit or fault) make that slot the most recently used.
- R9: A fill whose page and address-space number match an occupied slot overwrites that slot's frame number and permit bit. It does not create a second copy.
- R10: `flush_one` empties every slot whose address-space number equals `flush_one_asid` and leaves all other slots intact.
- R11: `flush_every` empties all slots.
- R12: Updates have a fixed priority: `flush_every`, then `flush_one`, then fill. A fill in a cycle with either flush high is ignored. A lookup sees the contents as they were before the updates of its own cycle.
- R13: After reset, all slots are empty and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asid | input | ASID_W | Address space of the lookup |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | No translation held |
| rsp_fault | output | 1 | Translation held but not permitted |
| rsp_pfn | output | PFN_W | Frame number on hit, else 0 |
| fill_req | input | 1 | Install a mapping |
| fill_vpn | input | VPN_W | Page number of the mapping |
| fill_asid | input | ASID_W | Address space of the mapping |
| fill_pfn | input | PFN_W | Frame number of the mapping |
| fill_perm | input | 1 | Permit bit of the mapping |
| flush_one | input | 1 | Drop mappings of one address space |
| flush_one_asid | input | ASID_W | Address space to drop |
| flush_every | input | 1 | Drop all mappings |

## Verification
A lookup result is registered, so it appears on the outputs one clock after the request. A fill, flush or recency change takes effect at the edge of its own cycle, so a lookup in the following cycle already sees it. The bench applies every stimulus on a falling edge and samples the result on the next falling edge, half a cycle after the edge that registered it. A shadow model in the bench records the last-use time of each slot and computes every expected outcome from that state as it stood before the current cycle's updates, which matches the rule in R12.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Outcome of one lookup, decoded onto the response flags.
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_MISS  = 2'd2,
    LK_FAULT = 2'd3
  } lk_kind_e;

endpackage

// File: rtl/tlb_cam.sv
// Parallel tag compare: one comparator per slot against a single key.
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             slot_used,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  slot_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] slot_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic [ENTRIES-1:0]             match_vec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = slot_used[i]
                        && (slot_vpn[i]  == key_vpn)
                        && (slot_asid[i] == key_asid);
  end

endmodule

// File: rtl/tlb_age.sv
// Recency ranks: each slot holds a rank in 0..ENTRIES-1, 0 = newest.
// The ranks always form a permutation; the slot with the top rank is oldest.
module tlb_age #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);

  logic [IDX_W-1:0] rank [ENTRIES];
  logic [IDX_W-1:0] touched_rank;

  assign touched_rank = rank[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ENTRIES; j++) rank[j] <= IDX_W'(j);
    end else if (touch_en) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == touch_idx)      rank[j] <= '0;
        else if (rank[j] < touched_rank) rank[j] <= rank[j] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (rank[j] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(j);
    end
  end

endmodule

// File: rtl/tlb_alloc.sv
// Picks the slot a fill writes: an existing copy of the key first,
// then the lowest empty slot, then the least recently used slot.
module tlb_alloc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] slot_used,
  input  logic [ENTRIES-1:0] dup_vec,
  input  logic [IDX_W-1:0]   oldest_idx,
  output logic [IDX_W-1:0]   wr_idx
);

  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] dup_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    dup_idx  = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_used[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
      if (dup_vec[i]) dup_idx = IDX_W'(i);
    end
    if (|dup_vec)      wr_idx = dup_idx;
    else if (any_free) wr_idx = free_idx;
    else               wr_idx = oldest_idx;
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  input  logic              fill_req,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_perm,
  input  logic              flush_one,
  input  logic [ASID_W-1:0] flush_one_asid,
  input  logic              flush_every
);

  // Slot state: occupancy bits are reset, payload arrays are not.
  logic [ENTRIES-1:0]             used_q;
  logic [ENTRIES-1:0]             perm_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;

  logic [ENTRIES-1:0] lk_vec;
  logic [ENTRIES-1:0] dup_vec;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   oldest_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               fill_go;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;
  lk_kind_e           lk_kind;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lk (
    .slot_used (used_q),
    .slot_vpn  (vpn_q),
    .slot_asid (asid_q),
    .key_vpn   (lk_vpn),
    .key_asid  (lk_asid),
    .match_vec (lk_vec)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
    .slot_used (used_q),
    .slot_vpn  (vpn_q),
    .slot_asid (asid_q),
    .key_vpn   (fill_vpn),
    .key_asid  (fill_asid),
    .match_vec (dup_vec)
  );

  tlb_age #(.ENTRIES(ENTRIES)) u_age (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .oldest_idx (oldest_idx)
  );

  tlb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .slot_used  (used_q),
    .dup_vec    (dup_vec),
    .oldest_idx (oldest_idx),
    .wr_idx     (wr_idx)
  );

  // Encode the (at most one-hot) lookup match vector.
  always_comb begin
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_vec[i]) lk_idx = IDX_W'(i);
    end
  end

  assign lk_any    = |lk_vec;
  assign fill_go   = fill_req && !flush_every && !flush_one;
  assign touch_en  = fill_go || (lk_req && lk_any);
  assign touch_idx = fill_go ? wr_idx : lk_idx;

  always_comb begin
    if (!lk_req)            lk_kind = LK_NONE;
    else if (!lk_any)       lk_kind = LK_MISS;
    else if (perm_q[lk_idx]) lk_kind = LK_HIT;
    else                    lk_kind = LK_FAULT;
  end

  // Occupancy: flush-all, then per-space flush, then fill.
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
    end else if (flush_every) begin
      used_q <= '0;
    end else if (flush_one) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (asid_q[i] == flush_one_asid) used_q[i] <= 1'b0;
      end
    end else if (fill_go) begin
      used_q[wr_idx] <= 1'b1;
    end
  end

  // Payload write port, one slot per cycle.
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[wr_idx]  <= fill_vpn;
      asid_q[wr_idx] <= fill_asid;
      pfn_q[wr_idx]  <= fill_pfn;
      perm_q[wr_idx] <= fill_perm;
    end
  end

  // Registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_valid <= (lk_kind != LK_NONE);
      rsp_hit   <= (lk_kind == LK_HIT);
      rsp_miss  <= (lk_kind == LK_MISS);
      rsp_fault <= (lk_kind == LK_FAULT);
      rsp_pfn   <= (lk_kind == LK_HIT) ? pfn_q[lk_idx] : '0;
    end
  end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 16,
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_req,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic [ASID_W-1:0] lk_asid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_fault,
  input logic [PFN_W-1:0]  rsp_pfn,
  input logic              fill_req,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [ASID_W-1:0] fill_asid,
  input logic              flush_one,
  input logic              flush_every
);

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault);

  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> rsp_pfn == '0);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_pfn == '0);

  assert_fill_visible_R6: assert property (@(posedge clk) disable iff (rst)
    (lk_req && $past(!rst) && $past(fill_req && !flush_one && !flush_every)
     && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid))
    |=> (rsp_hit || rsp_fault));

  assert_flush_all_R11: assert property (@(posedge clk) disable iff (rst)
    (flush_every ##1 lk_req) |=> rsp_miss);

endmodule

bind asid_tlb asid_tlb_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_req      (lk_req),
  .lk_vpn      (lk_vpn),
  .lk_asid     (lk_asid),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_miss    (rsp_miss),
  .rsp_fault   (rsp_fault),
  .rsp_pfn     (rsp_pfn),
  .fill_req    (fill_req),
  .fill_vpn    (fill_vpn),
  .fill_asid   (fill_asid),
  .flush_one   (flush_one),
  .flush_every (flush_every)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;

  localparam int N  = 8;
  localparam int VW = 20;
  localparam int PW = 16;
  localparam int AW = 8;
  localparam int K_HIT = 1, K_MISS = 2, K_FAULT = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          lk_req;
  logic [VW-1:0] lk_vpn;
  logic [AW-1:0] lk_asid;
  logic          rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [PW-1:0] rsp_pfn;
  logic          fill_req;
  logic [VW-1:0] fill_vpn;
  logic [AW-1:0] fill_asid;
  logic [PW-1:0] fill_pfn;
  logic          fill_perm;
  logic          flush_one;
  logic [AW-1:0] flush_one_asid;
  logic          flush_every;

  asid_tlb #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) uut (
    .clk(clk), .rst(rst),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn),
    .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush_one(flush_one), .flush_one_asid(flush_one_asid),
    .flush_every(flush_every)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Shadow model: slot contents plus last-use time stamps.
  bit m_used [N];
  int m_vpn  [N];
  int m_asid [N];
  int m_pfn  [N];
  bit m_ok   [N];
  int m_t    [N];
  int stamp = 1;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int out_kind();
    if (rsp_hit)   return K_HIT;
    if (rsp_miss)  return K_MISS;
    if (rsp_fault) return K_FAULT;
    return 0;
  endfunction

  task automatic step(input bit lk, input int lv, input int la,
                      input bit fl, input int fv, input int fa, input int fp, input bit fperm,
                      input bit f1, input int f1a, input bit fall, input string tag);
    int  e_i = 0;
    bit  e_any = 0;
    int  e_kind = 0;
    int  e_pfn = 0;
    bit  fe;
    int  w;
    bit  found;
    string t;
    lk_req = lk;  lk_vpn = lv[VW-1:0];  lk_asid = la[AW-1:0];
    fill_req = fl; fill_vpn = fv[VW-1:0]; fill_asid = fa[AW-1:0];
    fill_pfn = fp[PW-1:0]; fill_perm = fperm;
    flush_one = f1; flush_one_asid = f1a[AW-1:0]; flush_every = fall;
    for (int i = 0; i < N; i++)
      if (m_used[i] && m_vpn[i] == lv && m_asid[i] == la) begin e_any = 1; e_i = i; end
    if (lk) e_kind = !e_any ? K_MISS : (m_ok[e_i] ? K_HIT : K_FAULT);
    if (e_kind == K_HIT) e_pfn = m_pfn[e_i];
    fe = fl && !f1 && !fall;
    if (fall) begin
      for (int i = 0; i < N; i++) m_used[i] = 0;
    end else if (f1) begin
      for (int i = 0; i < N; i++) if (m_asid[i] == f1a) m_used[i] = 0;
    end
    if (fe) begin
      found = 0; w = 0;
      for (int i = 0; i < N; i++)
        if (!found && m_used[i] && m_vpn[i] == fv && m_asid[i] == fa) begin found = 1; w = i; end
      for (int i = 0; i < N; i++)
        if (!found && !m_used[i]) begin found = 1; w = i; end
      if (!found)
        for (int i = 0; i < N; i++) if (m_t[i] < m_t[w]) w = i;
      m_used[w] = 1; m_vpn[w] = fv; m_asid[w] = fa; m_pfn[w] = fp; m_ok[w] = fperm;
      m_t[w] = stamp;
    end else if (lk && e_any) begin
      m_t[e_i] = stamp;
    end
    stamp++;
    @(negedge clk);
    chk("R1", "rsp_valid", rsp_valid, lk);
    if (lk) begin
      if (tag != "") t = tag;
      else t = (e_kind == K_HIT) ? "R2" : (e_kind == K_MISS) ? "R3" : "R5";
      chk(t, "outcome", out_kind(), e_kind);
      chk(t, "rsp_pfn", rsp_pfn, e_pfn);
    end else begin
      chk("R1", "idle flags", {rsp_hit, rsp_miss, rsp_fault}, 0);
    end
  endtask

  task automatic look(input int v, input int a, input int k, input string tag);
    step(1, v, a, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    chk(tag, "directed outcome", out_kind(), k);
  endtask

  task automatic put(input int v, input int a, input int p, input bit ok);
    step(0, 0, 0, 1, v, a, p, ok, 0, 0, 0, "");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_used[i] = 0; m_t[i] = 0; end
    rst = 1; lk_req = 0; lk_vpn = '0; lk_asid = '0; fill_req = 0; fill_vpn = '0;
    fill_asid = '0; fill_pfn = '0; fill_perm = 0; flush_one = 0; flush_one_asid = '0;
    flush_every = 0;
    repeat (3) @(negedge clk);
    // R13: outputs quiet in reset, buffer empty afterwards
    chk("R13", "reset flags", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
    chk("R13", "reset pfn", rsp_pfn, 0);
    rst = 0;
    look(3, 1, K_MISS, "R13");

    // R7: eight fills into empty slots, all remain (page 5 not permitted: R5)
    for (int v = 0; v < 8; v++) put(v, 1, 'h100 + v * 7, v != 5);
    for (int v = 0; v < 8; v++) look(v, 1, (v == 5) ? K_FAULT : K_HIT, (v == 5) ? "R5" : "R7");

    // R4: same pages, other address space
    for (int v = 0; v < 8; v++) look(v, 2, K_MISS, "R4");

    // R8: refresh page 0, then a new fill evicts page 1
    look(0, 1, K_HIT, "R8");
    put(20, 1, 'h520, 1);
    look(1, 1, K_MISS, "R8");
    look(0, 1, K_HIT, "R8");
    look(20, 1, K_HIT, "R6");

    // R12: lookup in the fill's own cycle sees old contents; R6 next cycle
    step(1, 21, 1, 1, 21, 1, 'h321, 0, 0, 0, 0, "R12");
    chk("R12", "same-cycle outcome", out_kind(), K_MISS);
    look(21, 1, K_FAULT, "R6");

    // R9: refill same key rewrites frame and permit
    put(21, 1, 'h777, 1);
    look(21, 1, K_HIT, "R9");
    chk("R9", "rewritten pfn", rsp_pfn, 'h777);
    for (int v = 40; v < 47; v++) put(v, 3, v, 1);
    look(21, 1, K_HIT, "R9");
    chk("R9", "pfn after churn", rsp_pfn, 'h777);

    // R10: drop one address space only
    put(60, 4, 'h60, 1); put(61, 4, 'h61, 1); put(62, 5, 'h62, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0, "");
    look(60, 4, K_MISS, "R10");
    look(61, 4, K_MISS, "R10");
    look(62, 5, K_HIT, "R10");

    // R12: fill ignored under either flush
    step(0, 0, 0, 1, 70, 6, 'h70, 1, 1, 9, 0, "");
    look(70, 6, K_MISS, "R12");
    step(0, 0, 0, 1, 71, 6, 'h71, 1, 0, 0, 1, "");
    look(71, 6, K_MISS, "R12");

    // R11: drop everything
    put(80, 7, 'h80, 1); put(81, 8, 'h81, 1);
    look(80, 7, K_HIT, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "");
    look(80, 7, K_MISS, "R11");
    look(81, 8, K_MISS, "R11");

    // Mixed sweep against the shadow model (R2, R3, R5, R8 outcomes)
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom;
      step((r % 4) != 0, $urandom % 12, $urandom % 3,
           ((r >> 3) % 8) < 3, $urandom % 12, $urandom % 3, $urandom % 65536,
           ($urandom % 4) != 0,
           ((r >> 6) % 16) == 0, $urandom % 3,
           ((r >> 10) % 32) == 0, "");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule